// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the serial command engine of a small byte-wide nonvolatile memory. A host drives a four-wire serial bus (clock, select, data in, data out) plus a pause line and a write-protect line. The block samples these lines into its own clock domain and decodes a one-byte opcode, a 16-bit address and data bytes. It serves reads straight from an internal byte array and returns a status byte. Written bytes gather in a page buffer. The block works in serial clock modes 0 and 3.

A page write is not applied while the bus transfer runs. It is committed when select rises, and only if that happens on a byte boundary. A timed internal cycle then copies the buffered bytes into the array. The length of that cycle is a parameter counted in system clocks, so that busy polling can be exercised. The write-enable latch, the protect-zone bits and the hardware-protect enable are kept in a small status and protection unit. That unit grants or refuses page and status writes.

Top module: `spi_ee_front`

## Requirements
- R1: After reset the data output enable is low, `wr_busy` is low and the status byte reads 0x00.
- R2: `spi_so_en` is low whenever select is high or the pause line (`spi_hold_n`) is low.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 streams the status byte for as long as select stays low. In the status byte, bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect zone and bit 7 is the hardware-protect enable. All other bits read 0.
- R4: Opcode 0x03 takes a 16-bit address, sent MSB first, and ignores its upper 3 bits. It then returns consecutive bytes, and the address wraps from 0x1FFF to 0x0000.
- R5: Opcode 0x02 takes a 16-bit address and then data bytes. Data that runs past the end of the 64-byte page wraps to the start of that same page.
- R6: A page write is committed only if select rises on a byte boundary after at least one full data byte. Otherwise nothing in the array changes and busy stays low.
- R7: A committed write holds `wr_busy` high for exactly WRITE_CYCLES clocks, and status bit 0 reports the same state. The write-enable latch is cleared when the cycle starts.
- R8: While busy, opcodes 0x06, 0x04, 0x01, 0x03 and 0x02 are ignored, so a read returns 0x00 bytes. Opcode 0x05 still works.
- R9: A page write sent while the write-enable latch is clear is discarded.
- R10: Opcode 0x01 followed by one byte loads status bits 7 and 3:2 when the latch is set. The load is refused when bit 7 is already 1 and `spi_wp_n` is low. The opcode clears the latch in either case.
- R11: Protect zone 01 locks 0x1800-0x1FFF, zone 10 locks 0x1000-0x1FFF and zone 11 locks the whole array. A page write that starts in a locked zone is discarded.
- R12: While `spi_hold_n` is low, clock edges are ignored. The transfer resumes at the same bit once the line returns high.
- R13: In both modes 0 and 3, input is sampled on rising clock edges and output changes on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause line, active low |
| spi_wp_n | input | 1 | Hardware write-protect, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for the data out pad (low means high impedance) |
| wr_busy | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the block with the full 13-bit address and 64-byte pages, so that the page wrap and the wrap from 0x1FFF to 0x0000 are real corners. It uses WRITE_CYCLES = 600. That is long enough that status polls, a refused latch set and a refused read all fall inside one write cycle, and short enough that a dozen random page writes fit in the run. The serial clock runs at one tenth of the system clock, which leaves room for the input synchronizers and the registered array read.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_OP, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_SRD, ST_SWR, ST_SKIP
  } ee_state_e;

  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_WDIS  = 8'h04;
  localparam logic [7:0] OPC_RSTAT = 8'h05;
  localparam logic [7:0] OPC_WSTAT = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_PROG  = 8'h02;

  // zone: protect bits; top2: two most significant address bits
  function automatic logic zone_locked(input logic [1:0] zone, input logic [1:0] top2);
    case (zone)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{rst_val}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_ee_prot.sv
module spi_ee_prot (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       wp_n,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       sr_wr,
  input  logic [7:0] sr_data,
  input  logic [1:0] chk_top,
  output logic       grant_wr,
  output logic       grant_sr,
  output logic [7:0] status
);
  import spi_ee_pkg::*;

  logic       wel;
  logic       wpen;
  logic [1:0] zone;

  assign grant_sr = wel && !(wpen && !wp_n);
  assign grant_wr = wel && !zone_locked(zone, chk_top);
  assign status   = {wpen, 3'b000, zone, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      wpen <= 1'b0;
      zone <= 2'b00;
    end else begin
      if (wel_clr)      wel <= 1'b0;
      else if (wel_set) wel <= 1'b1;
      if (sr_wr && grant_sr) begin
        wpen <= sr_data[7];
        zone <= sr_data[3:2];
      end
    end
  end
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_off,
  input  logic [7:0]               buf_din,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_q,
  output logic                     busy
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [7:0]               pbuf [PAGE_N];
  logic [PAGE_N-1:0]        pvld;
  logic [7:0]               mem  [DEPTH];
  logic [PAGE_W:0]          cidx;
  logic [CNT_W-1:0]         tcnt;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic                     mem_we;

  assign mem_we = busy && !cidx[PAGE_W] && pvld[cidx[PAGE_W-1:0]];

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_off] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (rst || buf_clr) pvld <= '0;
    else if (buf_we)    pvld[buf_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{page_q, cidx[PAGE_W-1:0]}] <= pbuf[cidx[PAGE_W-1:0]];
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tcnt   <= '0;
      cidx   <= '0;
      page_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      tcnt   <= '0;
      cidx   <= '0;
      page_q <= page;
    end else if (busy) begin
      tcnt <= tcnt + CNT_W'(1);
      if (!cidx[PAGE_W]) cidx <= cidx + (PAGE_W+1)'(1);
      if (tcnt == CNT_W'(WRITE_CYCLES - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_ee_front.sv
module spi_ee_front #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  input  logic spi_hold_n,
  input  logic spi_wp_n,
  output logic spi_so,
  output logic spi_so_en,
  output logic wr_busy
);
  import spi_ee_pkg::*;

  localparam int PG_BITS = ADDR_W - PAGE_W;

  logic sck_s, si_s, cs_s, hold_s, wp_s;
  logic sck_p, cs_p;
  logic sck_rise, sck_fall, cs_rise, active, byte_done;
  logic [7:0] rx_next, stat_byte, out_byte, rd_q;
  logic [6:0] rx;
  logic [2:0] bitcnt;
  ee_state_e  st;
  logic [ADDR_W-9:0]  addr_hi;
  logic [ADDR_W-1:0]  rd_addr;
  logic [PG_BITS-1:0] wr_page;
  logic [PAGE_W-1:0]  wr_off;
  logic is_wr, have_data, so_q, so_en_q;
  logic wel_set, wel_clr, sr_wr, buf_clr, buf_we, wr_start, grant_wr, grant_sr;

  spi_ee_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_wp_n, spi_hold_n, spi_cs_n, spi_si, spi_sck}),
    .rst_val(5'b11100),
    .q({wp_s, hold_s, cs_s, si_s, sck_s})
  );

  always_ff @(posedge clk) begin
    if (rst) {cs_p, sck_p} <= 2'b10;
    else     {cs_p, sck_p} <= {cs_s, sck_s};
  end

  assign sck_rise  = sck_s && !sck_p;
  assign sck_fall  = !sck_s && sck_p;
  assign cs_rise   = cs_s && !cs_p;
  assign active    = !cs_s && hold_s;
  assign rx_next   = {rx, si_s};
  assign byte_done = active && sck_rise && (bitcnt == 3'd7);

  assign out_byte = (st == ST_SRD) ? stat_byte :
                    (st == ST_RD)  ? rd_q      : 8'h00;

  always_comb begin
    wel_set  = 1'b0;
    wel_clr  = 1'b0;
    sr_wr    = 1'b0;
    buf_clr  = 1'b0;
    buf_we   = 1'b0;
    wr_start = 1'b0;
    if (byte_done) begin
      case (st)
        ST_OP: begin
          wel_set = (rx_next == OPC_WEN)  && !wr_busy;
          wel_clr = (rx_next == OPC_WDIS) && !wr_busy;
        end
        ST_ALO: buf_clr = is_wr;
        ST_WR:  buf_we  = 1'b1;
        ST_SWR: begin
          sr_wr   = 1'b1;
          wel_clr = 1'b1;
        end
        default: ;
      endcase
    end
    if (cs_rise && st == ST_WR && bitcnt == 3'd0 && have_data && grant_wr) begin
      wr_start = 1'b1;
      wel_clr  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OP;
      bitcnt    <= '0;
      rx        <= '0;
      addr_hi   <= '0;
      rd_addr   <= '0;
      wr_page   <= '0;
      wr_off    <= '0;
      is_wr     <= 1'b0;
      have_data <= 1'b0;
      so_q      <= 1'b0;
      so_en_q   <= 1'b0;
    end else begin
      so_en_q <= !cs_s && hold_s;
      if (cs_s) begin
        st     <= ST_OP;
        bitcnt <= '0;
      end else if (active) begin
        if (sck_rise) begin
          rx     <= rx_next[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            case (st)
              ST_OP: begin
                is_wr <= (rx_next == OPC_PROG);
                case (rx_next)
                  OPC_RSTAT:          st <= ST_SRD;
                  OPC_WSTAT:          st <= wr_busy ? ST_SKIP : ST_SWR;
                  OPC_READ, OPC_PROG: st <= wr_busy ? ST_SKIP : ST_AHI;
                  default:            st <= ST_SKIP;
                endcase
              end
              ST_AHI: begin
                addr_hi <= rx_next[ADDR_W-9:0];
                st      <= ST_ALO;
              end
              ST_ALO: begin
                rd_addr   <= {addr_hi, rx_next};
                wr_page   <= {addr_hi, rx_next[7:PAGE_W]};
                wr_off    <= rx_next[PAGE_W-1:0];
                have_data <= 1'b0;
                st        <= is_wr ? ST_WR : ST_RD;
              end
              ST_RD: rd_addr <= rd_addr + ADDR_W'(1);
              ST_WR: begin
                wr_off    <= wr_off + PAGE_W'(1);
                have_data <= 1'b1;
              end
              ST_SWR: st <= ST_SKIP;
              default: ;
            endcase
          end
        end
        if (sck_fall) so_q <= out_byte[3'd7 - bitcnt];
      end
    end
  end

  spi_ee_prot u_prot (
    .clk(clk), .rst(rst), .busy(wr_busy), .wp_n(wp_s),
    .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr), .sr_data(rx_next),
    .chk_top(wr_page[PG_BITS-1 -: 2]),
    .grant_wr(grant_wr), .grant_sr(grant_sr), .status(stat_byte)
  );

  spi_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst(rst),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_off(wr_off), .buf_din(rx_next),
    .start(wr_start), .page(wr_page), .rd_addr(rd_addr),
    .rd_q(rd_q), .busy(wr_busy)
  );

  assign spi_so    = so_q;
  assign spi_so_en = so_en_q;
endmodule

// File: rtl/spi_ee_front_chk.sv
module spi_ee_front_chk #(
  parameter int WRITE_CYCLES = 5000
) (
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_hold_n,
  input logic       spi_so_en,
  input logic       wr_busy,
  input logic [7:1] stat
);
  logic [31:0] blen;

  always_ff @(posedge clk) begin
    if (rst)          blen <= '0;
    else if (wr_busy) blen <= blen + 32'd1;
    else              blen <= '0;
  end

  // R2
  cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_so_en);

  // R2
  hold_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (!spi_hold_n && !$past(spi_hold_n) && !$past(spi_hold_n, 2) && !$past(spi_hold_n, 3)) |-> !spi_so_en);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_busy) |-> (blen == 32'(WRITE_CYCLES)));

  // R7
  busy_wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> !stat[1]);

  // R8
  busy_status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && $past(wr_busy)) |-> $stable(stat[7:2]));

  // R8
  busy_no_wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && $past(wr_busy) && !$past(stat[1])) |-> !stat[1]);
endmodule

bind spi_ee_front spi_ee_front_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n),
  .spi_so_en(spi_so_en), .wr_busy(wr_busy), .stat(stat_byte[7:1])
);

// File: tb/spi_ee_front_bench.sv
module spi_ee_front_bench;
  localparam int WCYC = 600;
  localparam int H    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1, spi_wp_n = 1'b1;
  logic spi_so, spi_so_en, wr_busy;

  int nchk = 0, nerr = 0, run = 0, last_run = 0;
  bit mode3 = 1'b0;
  logic [7:0] wbuf [0:79];
  logic [7:0] rbuf [0:79];
  logic [7:0] model [0:8191];
  bit         known [0:8191];

  always #10 clk = ~clk;

  spi_ee_front #(.ADDR_W(13), .PAGE_W(6), .WRITE_CYCLES(WCYC)) u_spi_ee_front (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
    .spi_hold_n(spi_hold_n), .spi_wp_n(spi_wp_n), .spi_so(spi_so),
    .spi_so_en(spi_so_en), .wr_busy(wr_busy)
  );

  always @(negedge clk) begin
    if (wr_busy) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] page_addr(input logic [15:0] a, input int i);
    return {a[12:6], 6'(a[5:0] + i)};
  endfunction

  task automatic bits(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      spi_sck = 1'b0; spi_si = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = spi_so;
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = 8'h00;
    bits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic begin_xfer();
    spi_sck = mode3;
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic end_xfer();
    if (!mode3) begin
      spi_sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    begin_xfer(); xbyte(op, d); end_xfer();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    begin_xfer(); xbyte(8'h05, d); xbyte(8'h00, s); end_xfer();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    begin_xfer(); xbyte(8'h01, d); xbyte(v, d); end_xfer();
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    logic [7:0] d;
    begin_xfer();
    xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
    end_xfer();
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] d;
    begin_xfer();
    xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
    end_xfer();
  endtask

  task automatic commit_model(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      model[page_addr(a, i)] = wbuf[i];
      known[page_addr(a, i)] = 1'b1;
    end
  endtask

  task automatic wait_ready();
    while (wr_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v);
    cmd1(8'h06);
    wbuf[0] = v;
    do_write(a, 1);
    commit_model(a, 1);
    wait_ready();
  endtask

  initial begin
    logic [7:0] s, d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(spi_so_en == 1'b0, "R1", spi_so_en, 0);
    chk(wr_busy == 1'b0, "R1", wr_busy, 0);
    rdsr(s);
    chk(s == 8'h00, "R1", s, 8'h00);

    // R3 latch set / clear
    cmd1(8'h06); rdsr(s);
    chk(s == 8'h02, "R3", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    chk(s == 8'h00, "R3", s, 8'h00);

    // R2 output enable follows select
    chk(spi_so_en == 1'b0, "R2", spi_so_en, 0);
    begin_xfer(); xbyte(8'h05, d);
    chk(spi_so_en == 1'b1, "R2", spi_so_en, 1);
    xbyte(8'h00, d); end_xfer();

    // R5 R7 R8 page write, busy, refused commands while busy
    cmd1(8'h06);
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    do_write(16'h0010, 3);
    commit_model(16'h0010, 3);
    chk(wr_busy == 1'b1, "R7", wr_busy, 1);
    rdsr(s);
    chk(s == 8'h01, "R7", s, 8'h01);
    cmd1(8'h06); rdsr(s);
    chk(s == 8'h01, "R8", s, 8'h01);
    wait_ready();
    chk(last_run == WCYC, "R7", last_run, WCYC);
    do_read(16'h0010, 3);
    for (int i = 0; i < 3; i++) chk(rbuf[i] == model[13'h10 + i], "R5", rbuf[i], model[13'h10 + i]);

    // R4 upper address bits ignored
    do_read(16'hE011, 1);
    chk(rbuf[0] == 8'hBB, "R4", rbuf[0], 8'hBB);

    // R5 page wrap
    cmd1(8'h06);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h50 + 8'(i);
    do_write(16'h007E, 4);
    commit_model(16'h007E, 4);
    wait_ready();
    do_read(16'h0040, 2);
    chk(rbuf[0] == 8'h52 && rbuf[1] == 8'h53, "R5", {rbuf[0], rbuf[1]}, 16'h5253);
    do_read(16'h007E, 2);
    chk(rbuf[0] == 8'h50 && rbuf[1] == 8'h51, "R5", {rbuf[0], rbuf[1]}, 16'h5051);

    // R4 sequential read wraps from the top address; R8 read while busy
    write1(16'h0000, 8'hA5);
    cmd1(8'h06); wbuf[0] = 8'h5A; do_write(16'h1FFF, 1); commit_model(16'h1FFF, 1);
    do_read(16'h0010, 1);
    chk(rbuf[0] == 8'h00, "R8", rbuf[0], 8'h00);
    wait_ready();
    do_read(16'h1FFF, 2);
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hA5, "R4", {rbuf[0], rbuf[1]}, 16'h5AA5);

    // R6 partial byte and no-data writes are dropped
    write1(16'h0020, 8'h33);
    cmd1(8'h06);
    begin_xfer();
    xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h20, d); xbyte(8'h11, d);
    d = 8'h00; bits(8'h77, 7, 5, d);
    end_xfer();
    chk(wr_busy == 1'b0, "R6", wr_busy, 0);
    do_read(16'h0020, 2);
    chk(rbuf[0] == 8'h33, "R6", rbuf[0], 8'h33);
    do_write(16'h0020, 0);
    chk(wr_busy == 1'b0, "R6", wr_busy, 0);
    rdsr(s);
    chk(s == 8'h02, "R6", s, 8'h02);

    // R9 write without latch
    cmd1(8'h04);
    wbuf[0] = 8'h44; do_write(16'h0020, 1);
    chk(wr_busy == 1'b0, "R9", wr_busy, 0);
    do_read(16'h0020, 1);
    chk(rbuf[0] == 8'h33, "R9", rbuf[0], 8'h33);

    // R11 protect zones
    write1(16'h1800, 8'h11);
    cmd1(8'h06); wrsr(8'h04); rdsr(s);
    chk(s == 8'h04, "R10", s, 8'h04);
    cmd1(8'h06); wbuf[0] = 8'h77; do_write(16'h1800, 1);
    chk(wr_busy == 1'b0, "R11", wr_busy, 0);
    do_read(16'h1800, 1);
    chk(rbuf[0] == 8'h11, "R11", rbuf[0], 8'h11);
    cmd1(8'h04);
    write1(16'h17C0, 8'h66);
    do_read(16'h17C0, 1);
    chk(rbuf[0] == 8'h66, "R11", rbuf[0], 8'h66);
    cmd1(8'h06); wrsr(8'h08);
    cmd1(8'h06); wbuf[0] = 8'h99; do_write(16'h1000, 1);
    chk(wr_busy == 1'b0, "R11", wr_busy, 0);
    cmd1(8'h06); wrsr(8'h0C);
    cmd1(8'h06); do_write(16'h0020, 1);
    chk(wr_busy == 1'b0, "R11", wr_busy, 0);

    // R10 hardware protect blocks status writes
    cmd1(8'h06); wrsr(8'h80); rdsr(s);
    chk(s == 8'h80, "R10", s, 8'h80);
    spi_wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h0C); rdsr(s);
    chk(s == 8'h80, "R10", s, 8'h80);
    spi_wp_n = 1'b1;
    cmd1(8'h06); wrsr(8'h00); rdsr(s);
    chk(s == 8'h00, "R10", s, 8'h00);

    // R13 clock mode 3
    mode3 = 1'b1;
    do_read(16'h0010, 3);
    chk(rbuf[0] == 8'hAA && rbuf[2] == 8'hCC, "R13", {rbuf[0], rbuf[2]}, 16'hAACC);
    cmd1(8'h06); rdsr(s);
    chk(s == 8'h02, "R13", s, 8'h02);
    cmd1(8'h04);
    mode3 = 1'b0;

    // R12 pause in the middle of the address byte
    begin_xfer();
    xbyte(8'h03, d); xbyte(8'h00, d);
    d = 8'h00; bits(8'h11, 7, 4, d);
    spi_hold_n = 1'b0;
    repeat (H) @(negedge clk);
    chk(spi_so_en == 1'b0, "R12", spi_so_en, 0);
    for (int k = 0; k < 3; k++) begin
      spi_sck = 1'b0; spi_si = ~spi_si; repeat (H) @(negedge clk);
      spi_sck = 1'b1; repeat (H) @(negedge clk);
    end
    spi_hold_n = 1'b1;
    repeat (H) @(negedge clk);
    bits(8'h11, 3, 0, d);
    xbyte(8'h00, rbuf[0]);
    end_xfer();
    chk(rbuf[0] == 8'hBB, "R12", rbuf[0], 8'hBB);

    // R4 R5 random page writes and reads against the model
    for (int it = 0; it < 12; it++) begin
      logic [15:0] a, ra;
      int n, m;
      a = 16'($urandom_range(0, 16'hFFFF));
      n = $urandom_range(1, 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      cmd1(8'h06);
      do_write(a, n);
      commit_model(a, n);
      wait_ready();
      ra = {a[15:6], 6'($urandom_range(0, 63))};
      m = $urandom_range(1, 16);
      do_read(ra, m);
      for (int i = 0; i < m; i++) begin
        logic [12:0] ea;
        ea = 13'(ra[12:0] + 13'(i));
        if (known[ea]) chk(rbuf[i] == model[ea], "R4", rbuf[i], model[ea]);
      end
    end

    summary();
    $finish;
  end
endmodule